// File: doc/BRIEF.md
# DRAM Cycle Decoder with Compressed Test Mode

This block is a synthesizable, clock-sampled model of the control logic inside an asynchronous multiplexed-address DRAM. It is meant to stand on the far side of a memory controller under verification. The block samples the active-low row strobe, column strobe, write enable and output enable on every clock. It names each memory cycle when the row strobe falls, and it keeps the side-state a real device keeps: an 11-bit refresh row counter, a test-mode flag and a count of initialization cycles.

Storage is a small parameterised array of 16-bit words, split into a low half and a high half of 8 bits each. In normal operation, row address bit 10 selects which half a byte access uses. In test mode a write lands in both halves. A read then reports, for each bit, whether the two halves agree. A controller testbench drives the strobes at clock granularity. It watches the refresh strobe, the cycle code, the data bus and the protocol flag to judge how the controller behaves.

Top module: `dram_cycle_model`

## Requirements
- R1: After synchronous reset the data output is disabled, `test_mode`, `ref_stb` and `init_err` are 0, `cyc_kind` is 0 (idle), and the first counter refresh refreshes row 0.
- R2: A column access is a read when WE is high at the CAS fall and an early write when WE is low. Row bit 10 picks the high (1) or low (0) half, and the array word is chosen by row bits [3:0] and column bits [2:0]. `dq_oe` is 1 only for held read data while CAS and OE are both low. An early write never enables the output.
- R3: CAS low when RAS falls gives a counter refresh: `ref_stb` pulses for one clock with `ref_row` equal to the counter, and the counter then advances by one, wrapping from 2047 to 0.
- R4: A RAS-low period with no CAS fall is a RAS-only refresh. It is reported at the RAS rise with `ref_row` equal to the latched 11-bit row address, and it leaves the counter unchanged.
- R5: If CAS is still low from a read when RAS falls again, the cycle is a hidden refresh. It uses the counter, and the read data stays on the bus with `dq_oe` high.
- R6: CAS and WE low at the RAS fall with address bits [9:0] all 1 enters test mode, whatever bit 10 holds, and also refreshes by counter. Any other address gives a plain counter refresh.
- R7: In test mode, a counter refresh, a hidden refresh or a RAS-only refresh clears `test_mode`. A repeated test-entry cycle keeps it set.
- R8: In test mode a write stores the data byte into both halves, and a read returns, per bit, 1 where the halves are equal and 0 where they differ.
- R9: A WE fall while CAS is still low after a read writes the data input into the accessed location and disables the output.
- R10: A column access made before 8 RAS falls have been seen since reset sets `init_err`, which then stays set until reset.
- R11: Several CAS accesses within one RAS-low period all use the row latched at the RAS fall.
- R12: `cyc_kind` codes: 0 idle, 1 row opened, 2 read, 3 write, 4 counter refresh, 5 hidden refresh, 6 test entry, 7 RAS-only refresh. Each code is updated in the clock that sees the event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data (meaningful while dq_oe is 1) |
| dq_oe | output | 1 | Output driver enable; 0 means high impedance |
| test_mode | output | 1 | Compressed test mode active |
| ref_stb | output | 1 | One-clock pulse when a row is refreshed |
| ref_row | output | 11 | Row refreshed with the current pulse |
| cyc_kind | output | 3 | Code of the most recent cycle event |
| init_err | output | 1 | Sticky flag for an access before initialization |

## Verification
The hidden refresh is the case where two functions share one clock. The clock that sees RAS fall with CAS still held low must advance the refresh counter and may also end test mode. In that same clock, the read data from the previous access has to stay on the bus. The bench sets this up by raising and lowering RAS around a read without releasing CAS. In the clock after the second RAS fall it judges the refresh pulse, the counter row, the test flag and the unchanged output byte together.

// File: rtl/dram_cm_pkg.sv
// Package: shared cycle codes for the DRAM cycle model.
package dram_cm_pkg;
    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_ROW     = 3'd1,
        CYC_READ    = 3'd2,
        CYC_WRITE   = 3'd3,
        CYC_CBR     = 3'd4,
        CYC_HIDDEN  = 3'd5,
        CYC_TEST    = 3'd6,
        CYC_RASONLY = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/dram_cm_refresh_ctr.sv
// Module: refresh row counter. Advances by one on each counter-based
// refresh and wraps at 2**CNT_W. Assumes adv is a single-clock strobe.
module dram_cm_refresh_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);
    // Count refreshes; natural wrap at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_cm_cell_array.sv
// Module: two-half storage array. Normal writes and reads use one half.
// Test writes fill both halves, and test reads return a per-bit equality
// compare. Assumes one write port and one combinational read port.
module dram_cm_cell_array #(
    parameter int DW    = 8,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_both,
    input  logic             wr_half,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_half,
    input  logic             rd_cmp,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] half_rd [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [DW-1:0] mem [DEPTH];
        // Store into this half when selected or when both halves are written.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_both || (wr_half == 1'(h))))
                mem[wr_idx] <= wr_data;
        end
        assign half_rd[h] = mem[rd_idx];
    end

    logic [DW-1:0] cmp_bits;
    for (genvar b = 0; b < DW; b++) begin : g_cmp
        assign cmp_bits[b] = half_rd[0][b] ~^ half_rd[1][b];
    end

    // Select compressed result or the addressed half.
    always_comb begin
        if (rd_cmp)       rd_data = cmp_bits;
        else if (rd_half) rd_data = half_rd[1];
        else              rd_data = half_rd[0];
    end
endmodule

// File: rtl/dram_cm_classifier.sv
// Module: strobe-edge decoder. Detects RAS, CAS and WE edges on the clock
// and names each cycle. It also tracks the open row, the test flag and the
// initialization count. Assumes strobes are already synchronous to clk.
module dram_cm_classifier
    import dram_cm_pkg::*;
#(
    parameter int AW        = 11,
    parameter int COL_BITS  = 3,
    parameter int KEY_BITS  = 10,
    parameter int INIT_CYC  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [AW-1:0]       addr,
    input  logic                data_held,
    input  logic [AW-1:0]       cnt,
    output logic                cnt_adv,
    output logic                do_read,
    output logic                do_write,
    output logic                do_late,
    output logic [AW-1:0]       row_q,
    output logic [COL_BITS-1:0] col_q,
    output logic                test_mode,
    output logic                ref_stb,
    output logic [AW-1:0]       ref_row,
    output logic [2:0]          kind,
    output logic                init_err
);
    localparam int INIT_W = $clog2(INIT_CYC + 1);

    logic ras_q, cas_q, we_q;
    logic row_open, accessed;
    logic [INIT_W-1:0] init_cnt;
    cyc_kind_e kind_q, fall_kind;

    logic ras_fall, ras_rise, cas_fall, we_fall, access, ras_only, init_done, key_ok;

    assign ras_fall  = ras_q & ~ras_n;
    assign ras_rise  = ~ras_q & ras_n;
    assign cas_fall  = cas_q & ~cas_n;
    assign we_fall   = we_q & ~we_n;
    assign access    = cas_fall & row_open & ~ras_n;
    assign do_read   = access & we_n;
    assign do_write  = access & ~we_n;
    assign do_late   = we_fall & ~cas_fall & accessed & row_open & ~cas_n & ~ras_n;
    assign ras_only  = ras_rise & row_open & ~accessed;
    assign cnt_adv   = ras_fall & ~cas_n;
    assign init_done = (init_cnt >= INIT_W'(INIT_CYC));
    assign key_ok    = &addr[KEY_BITS-1:0];
    assign kind      = kind_q;

    // Name the cycle that a RAS fall starts.
    always_comb begin
        if (cas_n)               fall_kind = CYC_ROW;
        else if (data_held)      fall_kind = CYC_HIDDEN;
        else if (!we_n && key_ok) fall_kind = CYC_TEST;
        else                     fall_kind = CYC_CBR;
    end

    // Previous strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            we_q  <= we_n;
        end
    end

    // Cycle state: row, access, test flag, refresh report and cycle code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open  <= 1'b0;
            accessed  <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            test_mode <= 1'b0;
            ref_stb   <= 1'b0;
            ref_row   <= '0;
            kind_q    <= CYC_IDLE;
        end else begin
            ref_stb <= 1'b0;
            if (ras_fall) begin
                kind_q <= fall_kind;
                if (cas_n) begin
                    row_open <= 1'b1;
                    row_q    <= addr;
                end else begin
                    ref_stb <= 1'b1;
                    ref_row <= cnt;
                    test_mode <= (fall_kind == CYC_TEST);
                end
            end
            if (ras_rise) begin
                row_open <= 1'b0;
                accessed <= 1'b0;
                if (ras_only) begin
                    ref_stb   <= 1'b1;
                    ref_row   <= row_q;
                    kind_q    <= CYC_RASONLY;
                    test_mode <= 1'b0;
                end
            end
            if (access) begin
                accessed <= 1'b1;
                col_q    <= addr[COL_BITS-1:0];
                kind_q   <= we_n ? CYC_READ : CYC_WRITE;
            end
            if (do_late) kind_q <= CYC_WRITE;
        end
    end

    // Count RAS falls up to the initialization target; flag early accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt <= '0;
            init_err <= 1'b0;
        end else begin
            if (ras_fall && !init_done) init_cnt <= init_cnt + 1'b1;
            if (access && !init_done)   init_err <= 1'b1;
        end
    end
endmodule

// File: rtl/dram_cycle_model.sv
// Module: top of the DRAM cycle model. It joins the edge decoder, the
// refresh counter and the two-half array, and it holds the read data
// register. Assumes all strobes are sampled on clk; no analog timing.
module dram_cycle_model #(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3,
    parameter int HALF_BIT = 10,
    parameter int KEY_BITS = 10,
    parameter int INIT_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          test_mode,
    output logic          ref_stb,
    output logic [AW-1:0] ref_row,
    output logic [2:0]    cyc_kind,
    output logic          init_err
);
    localparam int IDX_W = ROW_BITS + COL_BITS;

    logic                cnt_adv, do_read, do_write, do_late;
    logic [AW-1:0]       ref_cnt, row_q;
    logic [COL_BITS-1:0] col_q, col_use;
    logic                out_valid;
    logic [DW-1:0]       dout_q, rd_data;

    dram_cm_refresh_ctr #(.CNT_W(AW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .adv(cnt_adv), .cnt(ref_cnt)
    );

    dram_cm_classifier #(
        .AW(AW), .COL_BITS(COL_BITS), .KEY_BITS(KEY_BITS), .INIT_CYC(INIT_CYC)
    ) u_cls (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .data_held(out_valid), .cnt(ref_cnt), .cnt_adv(cnt_adv),
        .do_read(do_read), .do_write(do_write), .do_late(do_late),
        .row_q(row_q), .col_q(col_q), .test_mode(test_mode),
        .ref_stb(ref_stb), .ref_row(ref_row), .kind(cyc_kind), .init_err(init_err)
    );

    assign col_use = do_write ? addr[COL_BITS-1:0] : col_q;

    dram_cm_cell_array #(.DW(DW), .IDX_W(IDX_W)) u_arr (
        .clk(clk),
        .wr_en(do_write | do_late),
        .wr_both(test_mode),
        .wr_half(row_q[HALF_BIT]),
        .wr_idx({row_q[ROW_BITS-1:0], col_use}),
        .wr_data(din),
        .rd_idx({row_q[ROW_BITS-1:0], addr[COL_BITS-1:0]}),
        .rd_half(row_q[HALF_BIT]),
        .rd_cmp(test_mode),
        .rd_data(rd_data)
    );

    // Capture read data; hold it while CAS stays low, drop it on write or CAS high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dout_q    <= '0;
        end else if (do_read) begin
            out_valid <= 1'b1;
            dout_q    <= rd_data;
        end else if (do_late || cas_n) begin
            out_valid <= 1'b0;
        end
    end

    assign dq_out = dout_q;
    assign dq_oe  = out_valid & ~cas_n & ~oe_n;
endmodule

// File: rtl/dram_cm_checker.sv
// Module: property checker for dram_cycle_model, attached by bind.
module dram_cm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        dq_oe,
    input logic        test_mode,
    input logic        ref_stb,
    input logic [2:0]  cyc_kind,
    input logic        init_err,
    input logic [10:0] ref_cnt
);
    // R3: the counter only moves with a counter-type refresh pulse
    a_r3_cnt_moves_on_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt != $past(ref_cnt)) |-> (ref_stb && (cyc_kind inside {3'd4, 3'd5, 3'd6})));

    // R12: a refresh pulse always carries a refresh cycle code
    a_r12_stb_has_refresh_kind: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> (cyc_kind inside {3'd4, 3'd5, 3'd6, 3'd7}));

    // R6: test mode is entered only by a test-entry cycle
    a_r6_entry_only_by_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (cyc_kind == 3'd6));

    // R7: test mode is left only through a refresh-type cycle
    a_r7_exit_by_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cyc_kind inside {3'd4, 3'd5, 3'd7}));

    // R2: the driver is on only after a read or across a hidden refresh
    a_r2_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (cyc_kind inside {3'd2, 3'd5}));

    // R10: the initialization flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_err) |-> init_err);
endmodule

bind dram_cycle_model dram_cm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .test_mode(test_mode),
    .ref_stb(ref_stb), .cyc_kind(cyc_kind), .init_err(init_err), .ref_cnt(ref_cnt)
);

// File: tb/tb_dram_cycle_model.sv
module tb_dram_cycle_model;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, ras_n, cas_n, we_n, oe_n;
    logic [10:0] addr;
    logic [7:0]  din, dq_out;
    logic dq_oe, test_mode, ref_stb, init_err;
    logic [10:0] ref_row;
    logic [2:0]  cyc_kind;

    dram_cycle_model dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .test_mode(test_mode), .ref_stb(ref_stb), .ref_row(ref_row),
        .cyc_kind(cyc_kind), .init_err(init_err)
    );

    int checks = 0, errors = 0;
    logic [7:0]  m_lo [128];
    logic [7:0]  m_hi [128];
    logic [10:0] exp_cnt;
    bit          tm_exp;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int idx(input logic [10:0] row, input logic [2:0] col);
        return int'({row[3:0], col});
    endfunction

    function automatic logic [7:0] exp_rd(input logic [10:0] row, input logic [2:0] col, input bit tm);
        if (tm) return ~(m_lo[idx(row, col)] ^ m_hi[idx(row, col)]);
        return row[10] ? m_hi[idx(row, col)] : m_lo[idx(row, col)];
    endfunction

    task automatic model_wr(input logic [10:0] row, input logic [2:0] col, input logic [7:0] d, input bit tm);
        if (tm || !row[10]) m_lo[idx(row, col)] = d;
        if (tm || row[10])  m_hi[idx(row, col)] = d;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_cnt = '0; tm_exp = 1'b0;
    endtask

    task automatic rw(input logic [10:0] row, input logic [2:0] col, input bit wr,
                      input logic [7:0] d, output logic [7:0] q, output logic oe, output logic [2:0] k);
        addr = row; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        addr = {8'h0, col}; we_n = ~wr; din = d; cas_n = 1'b0; @(negedge clk);
        q = dq_out; oe = dq_oe; k = cyc_kind;
        cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; @(negedge clk);
    endtask

    task automatic cbr(input bit we, input logic [10:0] a, output logic stb,
                       output logic [10:0] rr, output logic [2:0] k, output logic tm);
        cas_n = 1'b0; we_n = ~we; addr = a; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        stb = ref_stb; rr = ref_row; k = cyc_kind; tm = test_mode;
        ras_n = 1'b1; @(negedge clk);
        cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
    endtask

    task automatic ras_only(input logic [10:0] row, output logic stb,
                            output logic [10:0] rr, output logic [2:0] k, output logic tm);
        addr = row; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        ras_n = 1'b1; @(negedge clk);
        stb = ref_stb; rr = ref_row; k = cyc_kind; tm = test_mode;
        @(negedge clk);
    endtask

    task automatic hidden(input logic [10:0] row, input logic [2:0] col, output logic [7:0] q0,
                          output logic [7:0] q1, output logic oe1, output logic stb,
                          output logic [10:0] rr, output logic [2:0] k, output logic tm);
        addr = row; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        addr = {8'h0, col}; cas_n = 1'b0; @(negedge clk);
        q0 = dq_out;
        ras_n = 1'b1; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        q1 = dq_out; oe1 = dq_oe; stb = ref_stb; rr = ref_row; k = cyc_kind; tm = test_mode;
        ras_n = 1'b1; @(negedge clk);
        cas_n = 1'b1; @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] q, q1;
        logic oe, stb, tm;
        logic [10:0] rr;
        logic [2:0] k;
        void'($urandom(32'd20240611));

        // R1 reset state
        do_reset;
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 test_mode", test_mode, 0);
        chk("R1 ref_stb", ref_stb, 0);
        chk("R1 cyc_kind", cyc_kind, 0);
        chk("R1 init_err", init_err, 0);

        // R10 access before initialization
        rw(11'h001, 3'd1, 1'b0, 8'h00, q, oe, k);
        chk("R10 early access flagged", init_err, 1);
        repeat (2) @(negedge clk);
        chk("R10 flag sticky", init_err, 1);
        do_reset;
        chk("R1 init_err cleared", init_err, 0);

        // R3 eight initialization counter refreshes, first one at row 0 (R1)
        for (int i = 0; i < 8; i++) begin
            cbr(1'b0, 11'h000, stb, rr, k, tm);
            chk("R3 cbr stb", stb, 1);
            chk("R3 cbr row", rr, exp_cnt);
            chk("R12 cbr kind", k, 4);
            exp_cnt++;
        end

        // R2 prefill by early writes
        for (int r = 0; r < 16; r++)
            for (int h = 0; h < 2; h++)
                for (int c = 0; c < 8; c++) begin
                    logic [7:0] d;
                    logic [10:0] row;
                    d = 8'($urandom);
                    row = {1'(h), 6'($urandom), 4'(r)};
                    rw(row, 3'(c), 1'b1, d, q, oe, k);
                    model_wr(row, 3'(c), d, 1'b0);
                    if (r == 0 && c == 0) begin
                        chk("R2 early write hi-z", oe, 0);
                        chk("R12 write kind", k, 3);
                    end
                end
        chk("R10 no flag after init", init_err, 0);

        // R2 random reads and writes
        for (int n = 0; n < 300; n++) begin
            logic [10:0] row;
            logic [2:0] col;
            logic [7:0] d;
            row = 11'($urandom); col = 3'($urandom); d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                rw(row, col, 1'b0, 8'h00, q, oe, k);
                chk("R2 read data", q, exp_rd(row, col, 1'b0));
                chk("R2 read drive", oe, 1);
                chk("R12 read kind", k, 2);
            end else begin
                rw(row, col, 1'b1, d, q, oe, k);
                model_wr(row, col, d, 1'b0);
                chk("R2 write hi-z", oe, 0);
            end
        end

        // R2 OE high keeps bus off
        oe_n = 1'b1;
        rw(11'h003, 3'd2, 1'b0, 8'h00, q, oe, k);
        chk("R2 oe high hi-z", oe, 0);
        oe_n = 1'b0;

        // R11 fast page: two columns in one row cycle
        addr = 11'h405; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        addr = 11'h002; cas_n = 1'b0; @(negedge clk);
        chk("R11 page col a", dq_out, exp_rd(11'h405, 3'd2, 1'b0));
        cas_n = 1'b1; @(negedge clk);
        chk("R2 cas high hi-z", dq_oe, 0);
        addr = 11'h006; cas_n = 1'b0; @(negedge clk);
        chk("R11 page col b", dq_out, exp_rd(11'h405, 3'd6, 1'b0));
        cas_n = 1'b1; ras_n = 1'b1; @(negedge clk);

        // R4 RAS-only refresh
        ras_only(11'h5A3, stb, rr, k, tm);
        chk("R4 stb", stb, 1);
        chk("R4 row", rr, 11'h5A3);
        chk("R12 ras-only kind", k, 7);
        cbr(1'b0, 11'h000, stb, rr, k, tm);
        chk("R4 counter unchanged", rr, exp_cnt);
        exp_cnt++;

        // R5 hidden refresh keeps read data
        hidden(11'h00A, 3'd3, q, q1, oe, stb, rr, k, tm);
        chk("R5 read data", q, exp_rd(11'h00A, 3'd3, 1'b0));
        chk("R5 data held", q1, q);
        chk("R5 drive held", oe, 1);
        chk("R5 stb", stb, 1);
        chk("R5 counter row", rr, exp_cnt);
        chk("R12 hidden kind", k, 5);
        exp_cnt++;

        // R9 read-modify-write
        addr = 11'h00C; @(negedge clk);
        ras_n = 1'b0; @(negedge clk);
        addr = 11'h004; cas_n = 1'b0; @(negedge clk);
        chk("R9 read phase", dq_out, exp_rd(11'h00C, 3'd4, 1'b0));
        din = 8'h6E; we_n = 1'b0; @(negedge clk);
        chk("R9 drive off", dq_oe, 0);
        chk("R9 kind write", cyc_kind, 3);
        we_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; @(negedge clk);
        model_wr(11'h00C, 3'd4, 8'h6E, 1'b0);
        rw(11'h00C, 3'd4, 1'b0, 8'h00, q, oe, k);
        chk("R9 written", q, 8'h6E);

        // R6 test entry key
        cbr(1'b1, 11'h3FE, stb, rr, k, tm);
        chk("R6 wrong key no entry", tm, 0);
        chk("R6 wrong key is cbr", k, 4);
        exp_cnt++;
        rw(11'h001, 3'd0, 1'b1, 8'hA5, q, oe, k); model_wr(11'h001, 3'd0, 8'hA5, 1'b0);
        rw(11'h401, 3'd0, 1'b1, 8'hA0, q, oe, k); model_wr(11'h401, 3'd0, 8'hA0, 1'b0);
        cbr(1'b1, 11'h3FF, stb, rr, k, tm);
        chk("R6 entry", tm, 1);
        chk("R6 entry kind", k, 6);
        chk("R6 entry refresh row", rr, exp_cnt);
        exp_cnt++;

        // R8 compressed read and double write
        rw(11'h001, 3'd0, 1'b0, 8'h00, q, oe, k);
        chk("R8 compare read", q, 8'hFA);
        rw(11'h002, 3'd5, 1'b1, 8'h3C, q, oe, k); model_wr(11'h002, 3'd5, 8'h3C, 1'b1);
        rw(11'h002, 3'd5, 1'b0, 8'h00, q, oe, k);
        chk("R8 equal halves read", q, 8'hFF);

        // R7 repeated entry keeps, RAS-only exits
        cbr(1'b1, 11'h7FF, stb, rr, k, tm);
        chk("R7 re-entry keeps test", tm, 1);
        exp_cnt++;
        ras_only(11'h010, stb, rr, k, tm);
        chk("R7 ras-only exits", tm, 0);
        rw(11'h002, 3'd5, 1'b0, 8'h00, q, oe, k);
        chk("R8 low half written", q, 8'h3C);
        rw(11'h402, 3'd5, 1'b0, 8'h00, q, oe, k);
        chk("R8 high half written", q, 8'h3C);

        // R7 hidden exits (A10 ignored on entry, R6)
        cbr(1'b1, 11'h7FF, stb, rr, k, tm);
        chk("R6 entry A10 ignored", tm, 1);
        exp_cnt++;
        hidden(11'h001, 3'd0, q, q1, oe, stb, rr, k, tm);
        chk("R7 hidden exits", tm, 0);
        chk("R5 hidden in test data", q1, 8'hFA);
        chk("R5 hidden counter row", rr, exp_cnt);
        exp_cnt++;

        // R7 counter refresh exits
        cbr(1'b1, 11'h3FF, stb, rr, k, tm);
        exp_cnt++;
        cbr(1'b0, 11'h3FF, stb, rr, k, tm);
        chk("R7 cbr exits", tm, 0);
        exp_cnt++;

        // R3 counter wrap
        while (exp_cnt != 11'd0) begin
            cbr(1'b0, 11'h000, stb, rr, k, tm);
            if (exp_cnt == 11'd2047) chk("R3 row 2047", rr, 11'd2047);
            exp_cnt++;
        end
        cbr(1'b0, 11'h000, stb, rr, k, tm);
        chk("R3 wrap to 0", rr, 11'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule